// File: doc/BRIEF.md
# Clock Gear and Oscillator Switch Controller

This block manages three clock sources: an internal RC oscillator, a low-speed oscillator and a high-frequency crystal. It also derives the clock enables that the rest of the chip runs on. The oscillators are outside the block. Each one appears here as a one-cycle tick input, and every output is a one-cycle tick enable. A wait counter in the oscillator's own ticks runs each time an oscillator is switched on. The oscillator is reported ready only when that count completes. The wait length is chosen per oscillator from a 2-bit code, and code 0 gives the longest wait.

Software writes small control registers through a write port. A source-select register picks the high-speed clock (crystal or internal oscillator) and the system clock (low-speed oscillator or the high-speed clock). A selection that names a source which is not yet ready is held as a request. It takes effect on the cycle after that source becomes ready. The selected tick stream feeds three paths: a core path divided by a power-of-two gear, a peripheral path that can be gated off, and an auxiliary path with its own power-of-two divider.

Top module: `ckg_gear_ctrl`

## Requirements
- R1: Bits [7:6] of the oscillator-control register (address 1) set the internal-oscillator wait: code 0→64, 1→32, 2→16, 3→8 ticks. The code resets to 0. `iosc_rdy` goes high on the cycle after the tick that completes the count.
- R2: Bits [5:4] of address 1 set the crystal wait: code 0→1024, 1→512, 2→256, 3→128 crystal ticks. The code resets to 0.
- R3: The low-speed oscillator becomes ready after a fixed LS_WAIT (default 32) of its own ticks.
- R4: The enable bits at address 1 are bit 2 (internal oscillator, resets to 1), bit 1 (low-speed) and bit 0 (crystal). Clearing an enable drops that ready flag. Setting it again restarts the full wait.
- R5: Bit 0 of the source register (address 0) requests the low-speed oscillator (1) or the high-speed clock (0) as the system clock. `sys_is_ls` follows the request only once the target source is ready, one cycle after it becomes ready.
- R6: Bit 1 of address 0 requests the crystal (1) or the internal oscillator (0) as the high-speed clock. `hs_is_xtal` changes only once the requested oscillator is ready.
- R7: The gear code at address 4, bits [1:0], divides the core tick: 0→1/1, 1→1/2, 2→1/4, 3→1/8. It resets to 0.
- R8: The auxiliary divider code at address 2, bits [1:0], divides `aux_tick`: 0→1/1, 1→1/2, 2→1/4. The reserved code 3 acts as 1/1.
- R9: The peripheral enable at address 3, bits [1:0], resets to 3. `pclk_tick` follows the system tick only at code 3. Codes 0, 1 and 2 gate it off.
- R10: After reset every ready flag and tick output is 0, and the system clock is the internal oscillator. No tick is produced until the selected source is ready.
- R11: `sys_tick` reproduces the ticks of the currently selected source, one cycle later. Ticks of any other oscillator have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| iosc_tick | input | 1 | Internal oscillator tick |
| ls_tick | input | 1 | Low-speed oscillator tick |
| xtal_tick | input | 1 | Crystal oscillator tick |
| iosc_rdy | output | 1 | Internal oscillator settled |
| ls_rdy | output | 1 | Low-speed oscillator settled |
| xtal_rdy | output | 1 | Crystal settled |
| sys_is_ls | output | 1 | System clock currently low-speed |
| hs_is_xtal | output | 1 | High-speed clock currently the crystal |
| sys_tick | output | 1 | System clock enable |
| core_tick | output | 1 | Geared core clock enable |
| pclk_tick | output | 1 | Peripheral clock enable |
| aux_tick | output | 1 | Divided auxiliary clock enable |

## Verification
A wait counter that is off by one shows on a ready flag exactly one tick early or late. The bench therefore stops one tick short of each wait length and checks that the flag is still low, then gives the last tick. A selection latch that commits too early shows as `sys_is_ls` or `hs_is_xtal` flipping while the target ready flag is still low. A wrong mux shows within a few cycles as `sys_tick` pulses driven by an unselected oscillator. A divider mask fault changes the pulse count in any 16-tick window. The bench counts pulses over such windows, so a fault appears within one window and does not depend on the divider's phase.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADR_SRC  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_OSC  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_AUX  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_PCLK = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_GEAR = 3'd4;

  typedef struct packed {
    logic [1:0] iosc_wait;
    logic [1:0] xtal_wait;
    logic       iosc_en;
    logic       ls_en;
    logic       xtal_en;
  } osc_ctl_t;
endpackage

// File: rtl/ckg_osc_wait.sv
module ckg_osc_wait #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] target,
  output logic             rdy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      rdy <= 1'b0;
    end else if (tick && !rdy) begin
      if (({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, target}) begin
        rdy <= 1'b1;
        cnt <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R4: a disabled oscillator never reports ready
  assert_off_not_ready_R4: assert property (@(posedge clk) disable iff (rst)
    !en |=> !rdy);
  // R1: ready only appears right after one of its own ticks while enabled
  assert_ready_on_tick_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy) |-> ($past(tick) && $past(en)));
endmodule

// File: rtl/ckg_pow2_div.sv
module ckg_pow2_div #(
  parameter int LOG_MAX = 3,
  parameter int CODE_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  output logic              pulse
);
  logic [LOG_MAX-1:0] cnt;
  logic [LOG_MAX-1:0] mask;

  always_comb mask = ~({LOG_MAX{1'b1}} << code);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= tick && ((cnt & mask) == mask);
      if (tick) cnt <= cnt + LOG_MAX'(1);
    end
  end

  // R7: a divided pulse always stems from an input tick
  assert_pulse_needs_tick_R7: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(tick));
endmodule

// File: rtl/ckg_gear_ctrl.sv
module ckg_gear_ctrl
  import ckg_pkg::*;
#(
  parameter int IOSC_BASE = 64,
  parameter int XTAL_BASE = 1024,
  parameter int LS_WAIT   = 32,
  parameter int DIV_LOG   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              iosc_tick,
  input  logic              ls_tick,
  input  logic              xtal_tick,
  output logic              iosc_rdy,
  output logic              ls_rdy,
  output logic              xtal_rdy,
  output logic              sys_is_ls,
  output logic              hs_is_xtal,
  output logic              sys_tick,
  output logic              core_tick,
  output logic              pclk_tick,
  output logic              aux_tick
);
  localparam int CNT_W = $clog2(XTAL_BASE + 1);

  osc_ctl_t   osc_ctl;
  logic       req_ls, req_xtal;
  logic [1:0] aux_code, pclk_code, gear_code;
  logic [1:0] aux_eff;
  logic       pclk_on;
  logic [CNT_W-1:0] iosc_target, xtal_target, ls_target;
  logic       hs_rdy, sel_tick;

  // register decode
  always_ff @(posedge clk) begin
    if (rst) begin
      osc_ctl   <= '{iosc_wait: 2'd0, xtal_wait: 2'd0, iosc_en: 1'b1,
                     ls_en: 1'b0, xtal_en: 1'b0};
      req_ls    <= 1'b0;
      req_xtal  <= 1'b0;
      aux_code  <= 2'd0;
      pclk_code <= 2'd3;
      gear_code <= 2'd0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_SRC:  begin req_xtal <= wr_data[1]; req_ls <= wr_data[0]; end
        ADR_OSC:  osc_ctl <= '{iosc_wait: wr_data[7:6], xtal_wait: wr_data[5:4],
                               iosc_en: wr_data[2], ls_en: wr_data[1],
                               xtal_en: wr_data[0]};
        ADR_AUX:  aux_code  <= wr_data[1:0];
        ADR_PCLK: pclk_code <= wr_data[1:0];
        ADR_GEAR: gear_code <= wr_data[1:0];
        default:  ;
      endcase
    end
  end

  // wait targets: code 0 is the longest wait
  always_comb begin
    iosc_target = CNT_W'(IOSC_BASE >> osc_ctl.iosc_wait);
    xtal_target = CNT_W'(XTAL_BASE >> osc_ctl.xtal_wait);
    ls_target   = CNT_W'(LS_WAIT);
  end

  ckg_osc_wait #(.CNT_W(CNT_W)) u_wait_iosc (
    .clk(clk), .rst(rst), .en(osc_ctl.iosc_en), .tick(iosc_tick),
    .target(iosc_target), .rdy(iosc_rdy));
  ckg_osc_wait #(.CNT_W(CNT_W)) u_wait_ls (
    .clk(clk), .rst(rst), .en(osc_ctl.ls_en), .tick(ls_tick),
    .target(ls_target), .rdy(ls_rdy));
  ckg_osc_wait #(.CNT_W(CNT_W)) u_wait_xtal (
    .clk(clk), .rst(rst), .en(osc_ctl.xtal_en), .tick(xtal_tick),
    .target(xtal_target), .rdy(xtal_rdy));

  // pending selections commit only to a ready source
  always_ff @(posedge clk) begin
    if (rst) begin
      hs_is_xtal <= 1'b0;
      sys_is_ls  <= 1'b0;
    end else begin
      if (req_xtal ? xtal_rdy : iosc_rdy) hs_is_xtal <= req_xtal;
      if (req_ls ? ls_rdy : hs_rdy)       sys_is_ls  <= req_ls;
    end
  end

  always_comb begin
    hs_rdy = hs_is_xtal ? xtal_rdy : iosc_rdy;
    if (sys_is_ls) sel_tick = ls_tick && ls_rdy;
    else           sel_tick = hs_is_xtal ? (xtal_tick && xtal_rdy)
                                         : (iosc_tick && iosc_rdy);
    aux_eff = (aux_code == 2'd3) ? 2'd0 : aux_code;
    pclk_on = (pclk_code == 2'd3);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_tick  <= 1'b0;
      pclk_tick <= 1'b0;
    end else begin
      sys_tick  <= sel_tick;
      pclk_tick <= sel_tick && pclk_on;
    end
  end

  ckg_pow2_div #(.LOG_MAX(DIV_LOG), .CODE_W(2)) u_div_core (
    .clk(clk), .rst(rst), .tick(sel_tick), .code(gear_code), .pulse(core_tick));
  ckg_pow2_div #(.LOG_MAX(DIV_LOG), .CODE_W(2)) u_div_aux (
    .clk(clk), .rst(rst), .tick(sel_tick), .code(aux_eff), .pulse(aux_tick));

  // R5: low-speed selection commits only when that oscillator is ready
  assert_ls_commit_ready_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_is_ls) |-> $past(ls_rdy));
  // R6: crystal selection commits only when the crystal is ready
  assert_xtal_commit_ready_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_is_xtal) |-> $past(xtal_rdy));
  // R9: gated peripheral code yields no peripheral tick
  assert_pclk_gated_R9: assert property (@(posedge clk) disable iff (rst)
    (pclk_code != 2'd3) |=> !pclk_tick);
  // R10: no system tick without a ready selected source
  assert_tick_needs_ready_R10: assert property (@(posedge clk) disable iff (rst)
    sys_tick |-> $past(sys_is_ls ? ls_rdy : hs_rdy));
endmodule

// File: tb/ckg_gear_ctrl_tb.sv
module ckg_gear_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic iosc_tick = 1'b0, ls_tick = 1'b0, xtal_tick = 1'b0;
  logic iosc_rdy, ls_rdy, xtal_rdy, sys_is_ls, hs_is_xtal;
  logic sys_tick, core_tick, pclk_tick, aux_tick;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  ckg_gear_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .iosc_tick(iosc_tick), .ls_tick(ls_tick), .xtal_tick(xtal_tick),
    .iosc_rdy(iosc_rdy), .ls_rdy(ls_rdy), .xtal_rdy(xtal_rdy),
    .sys_is_ls(sys_is_ls), .hs_is_xtal(hs_is_xtal), .sys_tick(sys_tick),
    .core_tick(core_tick), .pclk_tick(pclk_tick), .aux_tick(aux_tick));

  // {addr, data, expected pulses in 16 ticks}; addr picks the observed output
  localparam logic [18:0] VEC [12] = '{
    {3'd4, 8'd0, 8'd16}, {3'd4, 8'd1, 8'd8}, {3'd4, 8'd2, 8'd4}, {3'd4, 8'd3, 8'd2},
    {3'd2, 8'd0, 8'd16}, {3'd2, 8'd1, 8'd8}, {3'd2, 8'd2, 8'd4}, {3'd2, 8'd3, 8'd16},
    {3'd3, 8'd0, 8'd0},  {3'd3, 8'd1, 8'd0}, {3'd3, 8'd2, 8'd0}, {3'd3, 8'd3, 8'd16}};

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ticks(input int which, input int n);
    @(negedge clk);
    if (which == 0) iosc_tick = 1'b1; else if (which == 1) ls_tick = 1'b1;
    else xtal_tick = 1'b1;
    repeat (n) @(negedge clk);
    iosc_tick = 1'b0; ls_tick = 1'b0; xtal_tick = 1'b0;
  endtask

  // count sys_tick over n source ticks plus one cycle of latency
  task automatic count_sys(input int which, input int n, output int c);
    c = 0;
    @(negedge clk);
    if (which == 0) iosc_tick = 1'b1; else xtal_tick = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); if (sys_tick) c++;
    end
    iosc_tick = 1'b0; xtal_tick = 1'b0;
    @(negedge clk); if (sys_tick) c++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 rdy flags", {iosc_rdy, ls_rdy, xtal_rdy}, 0);
    check("R10 selection", {sys_is_ls, hs_is_xtal}, 0);
    check("R10 ticks", {sys_tick, core_tick, pclk_tick, aux_tick}, 0);

    // R1 default 64-tick wait
    ticks(0, 63);
    check("R1 iosc not ready at 63", iosc_rdy, 0);
    check("R10 no tick before ready", sys_tick, 0);
    ticks(0, 1);
    check("R1 iosc ready at 64", iosc_rdy, 1);

    // R4 disable clears ready, re-enable with code 3 (8 ticks)
    wr(3'd1, 8'h00);
    @(negedge clk);
    check("R4 disabled not ready", iosc_rdy, 0);
    wr(3'd1, 8'hC4);
    ticks(0, 7);
    check("R1 code3 not ready at 7", iosc_rdy, 0);
    ticks(0, 1);
    check("R1 code3 ready at 8", iosc_rdy, 1);

    // R6 crystal request pending until ready
    wr(3'd0, 8'h02);
    @(negedge clk);
    check("R6 pending while xtal off", hs_is_xtal, 0);
    wr(3'd1, 8'hF5);
    ticks(2, 127);
    check("R2 code3 not ready at 127", xtal_rdy, 0);
    ticks(2, 1);
    check("R2 code3 ready at 128", xtal_rdy, 1);
    @(negedge clk);
    check("R6 xtal committed", hs_is_xtal, 1);

    // R11 only the selected source drives sys_tick
    count_sys(0, 8, c);
    check("R11 unselected iosc ignored", c, 0);
    count_sys(2, 8, c);
    check("R11 xtal ticks pass", c, 8);

    // R5 low-speed request pending until ready, R3 fixed wait
    wr(3'd0, 8'h03);
    @(negedge clk);
    check("R5 pending while ls off", sys_is_ls, 0);
    wr(3'd1, 8'hF7);
    ticks(1, 31);
    check("R3 ls not ready at 31", ls_rdy, 0);
    check("R5 still pending", sys_is_ls, 0);
    ticks(1, 1);
    check("R3 ls ready at 32", ls_rdy, 1);
    @(negedge clk);
    check("R5 ls committed", sys_is_ls, 1);

    // R2 longest crystal wait, code 0
    wr(3'd1, 8'hC6);
    @(negedge clk);
    check("R4 xtal disabled", xtal_rdy, 0);
    wr(3'd1, 8'hC7);
    ticks(2, 1023);
    check("R2 code0 not ready at 1023", xtal_rdy, 0);
    ticks(2, 1);
    check("R2 code0 ready at 1024", xtal_rdy, 1);

    // back to internal oscillator for the divider table
    wr(3'd0, 8'h00);
    repeat (2) @(negedge clk);
    check("R5 back to high-speed", sys_is_ls, 0);
    check("R6 back to iosc", hs_is_xtal, 0);

    iosc_tick = 1'b1;
    foreach (VEC[i]) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      repeat (3) @(negedge clk);
      c = 0;
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        case (VEC[i][18:16])
          3'd4: if (core_tick) c++;
          3'd2: if (aux_tick) c++;
          default: if (pclk_tick) c++;
        endcase
      end
      case (VEC[i][18:16])
        3'd4: check("R7 gear ratio", c, int'(VEC[i][7:0]));
        3'd2: check("R8 aux ratio", c, int'(VEC[i][7:0]));
        default: check("R9 pclk gate", c, int'(VEC[i][7:0]));
      endcase
    end
    iosc_tick = 1'b0;

    // R10 reset returns to initial selection
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R10 after reset", {iosc_rdy, ls_rdy, xtal_rdy, sys_is_ls, hs_is_xtal}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule